// File: doc/BRIEF.md
# Storage-Card to Serial Configuration Streamer

This block copies a configuration image, bit by bit, from a storage card that is read in fixed blocks into the serial configuration input of a programmable device. The card's data line is wired straight to the device's configuration data pin. The block never holds a data bit. It only drives the card clock and the configuration clock, and it asks the card for each block in turn.

For each block the block issues a read command through a valid/ready handshake. It then pulses the card clock until the card signals a start token. Each data bit then gets one paired pulse: the card clock rises first and the configuration clock rises later. After a full block, the check bits that trail it are clocked out of the card alone, so the device never sees them.

Streaming stops when the programmed image length has been delivered, which may be partway through the last block. The block then reports completion. A token that never arrives raises an error instead. Checking the integrity of the image is left to the device being configured.

Top module: `cfg_stream_loader`

## Requirements
- R1: During and after reset, before any start, `card_clk`, `cfg_clk`, `cmd_valid`, `done` and `error` are all low.
- R2: Each block is requested by raising `cmd_valid` with `cmd_block` holding the block index. The index is 0 for the first block of an image and rises by one per block. `cmd_valid` and `cmd_block` stay unchanged until a cycle with `cmd_ready` high.
- R3: After a request is accepted, `card_clk` pulses while `cfg_clk` stays low. A start token is `card_dat` sampled low in the last system cycle of a card-clock pulse. The pulse that carries the token is the last one before data.
- R4: A full block carries exactly 4096 data bits. Each bit gets one `cfg_clk` pulse, and the value on `card_dat` at each `cfg_clk` rise is the card's next data bit, in order.
- R5: A bit period lasts 3 system cycles. `card_clk` is high for the first 2 and `cfg_clk` only for the second. `cfg_clk` is therefore never high without `card_clk`, rises one cycle after it, and both fall on the same edge.
- R6: After each full block that does not end the image, exactly 16 further `card_clk` pulses follow with `cfg_clk` low. The next request comes after them.
- R7: The total number of `cfg_clk` pulses equals `image_bits`. `done` then goes high and no further request or clock pulse is issued.
- R8: A start with `image_bits` equal to 0 raises `done` without any request or clock pulse.
- R9: If no start token is seen within 4096 system cycles of waiting, `error` goes high, both clocks stop and no data pulse is issued.
- R10: `done` and `error` are never high together. Each holds until the next start, and a start with a non-zero length clears both.
- R11: A start pulse while an image is being streamed has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a transfer when idle, done or failed |
| image_bits | input | 32 | Image length in bits, sampled at start |
| cmd_valid | output | 1 | Block read request pending |
| cmd_block | output | 16 | Index of the requested block |
| cmd_ready | input | 1 | Request accepted by the card command logic |
| card_dat | input | 1 | Card data line (also wired to the device data pin) |
| card_clk | output | 1 | Clock to the storage card |
| cfg_clk | output | 1 | Clock to the configuration port |
| done | output | 1 | Image fully streamed |
| error | output | 1 | Start token wait timed out |

## Verification
The hardest case to reach from the ports is the boundary between blocks. There, the 16 check bits must be clocked out of the card with the configuration clock held low, and the next request must follow at once. A lost or extra pulse at that point shifts every later bit by one.

The bench's card model serves a distinct bit pattern per block and counts every card-clock rise from the acknowledge onward. A scoreboard pops the expected bit at each configuration-clock rise. An image of three blocks ending partway through the third therefore exposes any slip at two boundaries and at the early stop. Exact and one-block lengths exercise the case where the final block ends with no check-bit skip. A card that never sends a token drives the timeout path.

// File: rtl/cfg_stream_pkg.sv
// Shared types for the configuration streamer.
// Assumes: nothing beyond SystemVerilog 2017.
package cfg_stream_pkg;

    // Sequencer states; DONE and FAIL are resting states left only on start.
    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_REQ  = 3'd1,
        SEQ_WAIT = 3'd2,
        SEQ_DATA = 3'd3,
        SEQ_SKIP = 3'd4,
        SEQ_DONE = 3'd5,
        SEQ_FAIL = 3'd6
    } seq_state_t;

endpackage

// File: rtl/stream_bit_pacer.sv
// Bit-period generator. While run is high it cycles a phase counter over
// DIV system cycles: the card clock is high for phases 0..DIV-2, the
// configuration window for phases 1..DIV-2, and tick_end marks phase DIV-1.
// Assumes: DIV >= 3 so the configuration window is never empty.
module stream_bit_pacer #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic card_hi,
    output logic cfg_win,
    output logic tick_end
);
    localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HI   = PH_W'(DIV - 2);

    logic [PH_W-1:0] phase_q;

    // Phase counter: restarts at 0 whenever the pacer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    // Clock shapes decoded from the phase.
    always_comb begin
        card_hi  = run && (phase_q <= PH_HI);
        cfg_win  = run && (phase_q != '0) && (phase_q <= PH_HI);
        tick_end = run && (phase_q == PH_LAST);
    end
endmodule

// File: rtl/stream_span_counter.sv
// Plain up-counter with synchronous clear, used for positions inside a
// block and inside the check-bit tail.
// Assumes: the caller clears it before the count can wrap.
module stream_span_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (inc)      count <= count + 1'b1;
    end
endmodule

// File: rtl/stream_token_timer.sv
// Timeout for the start-token wait: counts cycles while armed and flags
// expiry in the LIMIT-th armed cycle.
// Assumes: LIMIT >= 2; disarming clears the count.
module stream_token_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expired
);
    localparam int TW = $clog2(LIMIT);
    localparam logic [TW-1:0] T_LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_q;

    // Wait-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) cnt_q <= '0;
        else if (cnt_q != T_LAST) cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag.
    always_comb expired = arm && (cnt_q == T_LAST);
endmodule

// File: rtl/stream_block_seq.sv
// Block sequencer: requests blocks, waits for the start token, counts data
// bits within the block and across the image, skips the trailing check bits
// and stops at the image length.
// Assumes: tick_end comes from the pacer and marks the last cycle of a pulse;
// card_dat is stable during that cycle.
module stream_block_seq
    import cfg_stream_pkg::*;
#(
    parameter int BLK_BITS = 4096,
    parameter int CRC_BITS = 16,
    parameter int LEN_W    = 32,
    parameter int BLK_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] image_bits,
    input  logic             cmd_ready,
    input  logic             card_dat,
    input  logic             tick_end,
    input  logic             tmo_expired,
    output logic             cmd_valid,
    output logic [BLK_W-1:0] cmd_block,
    output logic             pace_run,
    output logic             cfg_en,
    output logic             tmo_arm,
    output logic             done,
    output logic             error
);
    localparam int BIT_CW = $clog2(BLK_BITS);
    localparam int CRC_CW = (CRC_BITS > 1) ? $clog2(CRC_BITS) : 1;
    localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(BLK_BITS - 1);
    localparam bit HAS_CRC = (CRC_BITS > 0);

    seq_state_t       state_q, state_d;
    logic [LEN_W-1:0] left_q;
    logic [BLK_W-1:0] blk_q;
    logic [BIT_CW-1:0] bit_pos;
    logic             start_ok, adv_blk, data_tick, skip_tick, crc_last;

    // Accept start only when no transfer is in flight.
    always_comb begin
        start_ok = start && (state_q == SEQ_IDLE || state_q == SEQ_DONE
                             || state_q == SEQ_FAIL);
        data_tick = (state_q == SEQ_DATA) && tick_end;
        skip_tick = (state_q == SEQ_SKIP) && tick_end;
    end

    // Position of the current bit inside the block.
    stream_span_counter #(.W(BIT_CW)) u_bitpos (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != SEQ_DATA),
        .inc   (data_tick),
        .count (bit_pos)
    );

    // Check-bit tail counter only exists when a tail is configured.
    generate
        if (HAS_CRC) begin : g_tail
            logic [CRC_CW-1:0] crc_pos;
            stream_span_counter #(.W(CRC_CW)) u_crcpos (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (state_q != SEQ_SKIP),
                .inc   (skip_tick),
                .count (crc_pos)
            );
            assign crc_last = (crc_pos == CRC_CW'(CRC_BITS - 1));
        end else begin : g_notail
            assign crc_last = 1'b1;
        end
    endgenerate

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        adv_blk = 1'b0;
        case (state_q)
            SEQ_IDLE, SEQ_DONE, SEQ_FAIL: begin
                if (start_ok) state_d = (image_bits == '0) ? SEQ_DONE : SEQ_REQ;
            end
            SEQ_REQ: begin
                if (cmd_ready) state_d = SEQ_WAIT;
            end
            SEQ_WAIT: begin
                if (tick_end && !card_dat) state_d = SEQ_DATA;
                else if (tmo_expired)      state_d = SEQ_FAIL;
            end
            SEQ_DATA: begin
                if (data_tick) begin
                    if (left_q == LEN_W'(1)) state_d = SEQ_DONE;
                    else if (bit_pos == BIT_LAST) begin
                        if (HAS_CRC) state_d = SEQ_SKIP;
                        else begin
                            state_d = SEQ_REQ;
                            adv_blk = 1'b1;
                        end
                    end
                end
            end
            SEQ_SKIP: begin
                if (skip_tick && crc_last) begin
                    state_d = SEQ_REQ;
                    adv_blk = 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // State, remaining length and block index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            left_q  <= '0;
            blk_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_ok)       left_q <= image_bits;
            else if (data_tick) left_q <= left_q - 1'b1;
            if (start_ok)     blk_q <= '0;
            else if (adv_blk) blk_q <= blk_q + 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        cmd_valid = (state_q == SEQ_REQ);
        cmd_block = blk_q;
        pace_run  = (state_q == SEQ_WAIT) || (state_q == SEQ_DATA)
                    || (state_q == SEQ_SKIP);
        cfg_en    = (state_q == SEQ_DATA);
        tmo_arm   = (state_q == SEQ_WAIT);
        done      = (state_q == SEQ_DONE);
        error     = (state_q == SEQ_FAIL);
    end
endmodule

// File: rtl/cfg_stream_loader.sv
// Top level: streams an image from a block-read storage card to a serial
// configuration port by generating only the two clocks. The card data line
// feeds the configuration data pin outside this block.
// Assumes: DIV >= 3; the card presents a new bit after each card-clock rise.
module cfg_stream_loader #(
    parameter int BLK_BITS       = 4096,
    parameter int CRC_BITS       = 16,
    parameter int DIV            = 3,
    parameter int TOKEN_WAIT_CYC = 4096,
    parameter int LEN_W          = 32,
    parameter int BLK_W          = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] image_bits,
    output logic             cmd_valid,
    output logic [BLK_W-1:0] cmd_block,
    input  logic             cmd_ready,
    input  logic             card_dat,
    output logic             card_clk,
    output logic             cfg_clk,
    output logic             done,
    output logic             error
);
    logic pace_run, cfg_en, tmo_arm, tmo_expired;
    logic card_hi, cfg_win, tick_end;

    stream_bit_pacer #(.DIV(DIV)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pace_run),
        .card_hi  (card_hi),
        .cfg_win  (cfg_win),
        .tick_end (tick_end)
    );

    stream_token_timer #(.LIMIT(TOKEN_WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (tmo_arm),
        .expired (tmo_expired)
    );

    stream_block_seq #(
        .BLK_BITS (BLK_BITS),
        .CRC_BITS (CRC_BITS),
        .LEN_W    (LEN_W),
        .BLK_W    (BLK_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .image_bits  (image_bits),
        .cmd_ready   (cmd_ready),
        .card_dat    (card_dat),
        .tick_end    (tick_end),
        .tmo_expired (tmo_expired),
        .cmd_valid   (cmd_valid),
        .cmd_block   (cmd_block),
        .pace_run    (pace_run),
        .cfg_en      (cfg_en),
        .tmo_arm     (tmo_arm),
        .done        (done),
        .error       (error)
    );

    // Clock outputs: configuration pulses only while data bits flow.
    always_comb begin
        card_clk = card_hi;
        cfg_clk  = cfg_win && cfg_en;
    end
endmodule

// File: rtl/cfg_stream_loader_chk.sv
// Port-level protocol checks for cfg_stream_loader, bound to every instance.
// Assumes: synchronous active-low reset.
module cfg_stream_loader_chk #(
    parameter int BLK_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cmd_valid,
    input logic [BLK_W-1:0] cmd_block,
    input logic             cmd_ready,
    input logic             card_clk,
    input logic             cfg_clk,
    input logic             done,
    input logic             error
);
    // R5
    cfg_after_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $past(card_clk));
    // R5
    fall_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk) |-> $fell(card_clk));
    // R5
    cfg_inside_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> card_clk);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_block));
    // R3
    quiet_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !card_clk && !cfg_clk);
    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !card_clk && !cmd_valid);
    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !card_clk && !cfg_clk && !cmd_valid);
    // R10
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    // R10
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    // R10
    error_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error && !start |=> error);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(.BLK_W(BLK_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_block (cmd_block),
    .cmd_ready (cmd_ready),
    .card_clk  (card_clk),
    .cfg_clk   (cfg_clk),
    .done      (done),
    .error     (error)
);

// File: tb/cfg_stream_loader_tb.sv
// Scoreboard bench: a card model serves blocks and pushes the data bits it
// presents into a queue; a monitor pops one per configuration-clock rise.
module cfg_stream_loader_tb;
    localparam int BLK  = 4096;
    localparam int CRC  = 16;
    localparam int DIV  = 3;
    localparam int TMO  = 4096;
    localparam int LAT  = 20;
    localparam int TOTAL = LAT + 1 + BLK + CRC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] image_bits = '0;
    logic        cmd_valid;
    logic [15:0] cmd_block;
    logic        cmd_ready = 1'b0;
    logic        card_dat = 1'b1;
    logic        card_clk, cfg_clk, done, error;

    always #2.5 clk = ~clk;

    cfg_stream_loader #(
        .BLK_BITS(BLK), .CRC_BITS(CRC), .DIV(DIV), .TOKEN_WAIT_CYC(TMO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .image_bits(image_bits),
        .cmd_valid(cmd_valid), .cmd_block(cmd_block), .cmd_ready(cmd_ready),
        .card_dat(card_dat), .card_clk(card_clk), .cfg_clk(cfg_clk),
        .done(done), .error(error)
    );

    int checks = 0;
    int fails  = 0;
    logic exp_q[$];
    int   req_q[$];
    int   img_n = 0;
    int   pushed = 0;
    int   cfg_cnt = 0;
    int   card_cnt = 0;
    int   shape_bad = 0;
    bit   tok_off = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pat(input int b, input int j);
        int v;
        v = (j * 5 + b * 3) ^ (j >> 3);
        return v[0];
    endfunction

    // Card model (driver): acknowledges requests, sends token, data, tail.
    initial begin
        int mode, wait_n, k, blk;
        logic prev;
        mode = 0; wait_n = 0; k = 0; blk = 0; prev = 1'b0;
        forever begin
            @(negedge clk);
            if (mode == 3) begin
                cmd_ready = 1'b0;
                k = 0;
                mode = 2;
            end
            if (mode == 1) begin
                if (wait_n > 0) wait_n--;
                else begin
                    cmd_ready = 1'b1;
                    blk = int'(cmd_block);
                    req_q.push_back(blk);
                    card_dat = 1'b1;
                    mode = 3;
                end
            end
            if (mode == 0 && cmd_valid && !cmd_ready) begin
                wait_n = 2;
                mode = 1;
            end
            if (mode == 2 && card_clk && !prev) begin
                k++;
                if (tok_off)             card_dat = 1'b1;
                else if (k <= LAT)       card_dat = 1'b1;
                else if (k == LAT + 1)   card_dat = 1'b0;
                else if (k <= LAT + 1 + BLK) begin
                    card_dat = pat(blk, k - LAT - 2);
                    if (pushed < img_n) begin
                        exp_q.push_back(card_dat);
                        pushed++;
                    end
                end else card_dat = k[0];
                if (k == TOTAL) mode = 0;
            end
            if (mode == 2 && (done || error)) mode = 0;
            prev = card_clk;
        end
    end

    // Monitor: pops expected bits on configuration-clock rises; checks shape.
    initial begin
        logic cprev, kprev;
        int run;
        cprev = 1'b0; kprev = 1'b0; run = 0;
        forever begin
            @(negedge clk);
            if (cfg_clk && !cprev) begin
                cfg_cnt++;
                if (exp_q.size() == 0) chk(1'b0, "R4 unexpected cfg bit", cfg_cnt, pushed);
                else begin
                    logic e;
                    e = exp_q.pop_front();
                    // R4 bit passed straight through in order
                    chk(card_dat == e, "R4 data bit", int'(card_dat), int'(e));
                end
            end
            if (card_clk && !kprev) card_cnt++;
            if (card_clk) run++;
            if (!card_clk && kprev) begin
                if (run != DIV - 1) shape_bad++;
                run = 0;
            end
            cprev = cfg_clk;
            kprev = card_clk;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_img(input int n, input bit mid, output int cyc);
        img_n = n; pushed = 0; cfg_cnt = 0; card_cnt = 0; shape_bad = 0;
        exp_q.delete(); req_q.delete();
        image_bits = n;
        pulse_start();
        if (n > 0) chk(!done && !error, "R10 flags cleared by start", int'(done), 0);
        cyc = 0;
        if (mid) begin
            repeat (3000) @(negedge clk);
            cyc = 3001;
            start = 1'b1; @(negedge clk); start = 1'b0;   // R11
        end
        while (!(done || error) && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc < 60000, "watchdog", cyc, 60000);
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_image(input int n, input string tag);
        int nb, exp_card;
        nb = (n + BLK - 1) / BLK;
        exp_card = nb * (LAT + 1) + n + (nb - 1) * CRC;
        chk(done && !error, {tag, " R7 done"}, int'(done), 1);
        chk(cfg_cnt == n, {tag, " R7 cfg pulse count"}, cfg_cnt, n);
        chk(exp_q.size() == 0, {tag, " R4 all bits delivered"}, exp_q.size(), 0);
        chk(req_q.size() == nb, {tag, " R2 request count"}, req_q.size(), nb);
        for (int i = 0; i < req_q.size(); i++)
            chk(req_q[i] == i, {tag, " R2 block index"}, req_q[i], i);
        // R3 R6: token waits, data and tails seen on the card clock
        chk(card_cnt == exp_card, {tag, " R6 card pulse count"}, card_cnt, exp_card);
        chk(shape_bad == 0, {tag, " R5 pulse shape"}, shape_bad, 0);
    endtask

    initial begin
        int cyc, snap;
        repeat (4) @(negedge clk);
        chk(!card_clk && !cfg_clk, "R1 clocks low in reset", int'(card_clk), 0);
        chk(!cmd_valid && !done && !error, "R1 flags low in reset", int'(cmd_valid), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!card_clk && !cfg_clk && !cmd_valid, "R1 idle after reset", int'(card_clk), 0);
        chk(!done && !error, "R1 no status after reset", int'(done), 0);

        // Two blocks, ending partway through the second.
        run_img(5000, 1'b0, cyc);
        expect_image(5000, "T1");
        snap = card_cnt;
        repeat (30) @(negedge clk);
        chk(done, "R10 done holds", int'(done), 1);
        chk(card_cnt == snap && !cmd_valid, "R7 quiet after done", card_cnt, snap);

        // Exactly one block, with a stray start mid-stream.
        run_img(4096, 1'b1, cyc);
        expect_image(4096, "T2 R11");

        // Zero length.
        run_img(0, 1'b0, cyc);
        chk(done && cyc <= 2, "R8 immediate done", cyc, 1);
        chk(req_q.size() == 0 && card_cnt == 0, "R8 no request or pulse", card_cnt, 0);

        // Three blocks, two boundaries.
        run_img(8292, 1'b0, cyc);
        expect_image(8292, "T4");

        // Token never arrives.
        tok_off = 1'b1;
        run_img(100, 1'b0, cyc);
        tok_off = 1'b0;
        chk(error && !done, "R9 error raised", int'(error), 1);
        chk(cyc >= TMO && cyc <= TMO + 10, "R9 timeout window", cyc, TMO);
        chk(cfg_cnt == 0, "R9 no data pulses", cfg_cnt, 0);
        snap = card_cnt;
        repeat (30) @(negedge clk);
        chk(card_cnt == snap && error, "R9 R10 clocks stopped, error held", card_cnt, snap);

        // Recovery after error.
        run_img(300, 1'b0, cyc);
        expect_image(300, "T6");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Overall watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog overall run limit actual=190000 expected<190000");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule